// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block decides when an SDRAM controller must spend a command slot on refresh, and it runs the low-power sequence in which the memory refreshes itself. It does not drive the command bus. It raises a refresh request toward the controller's command arbiter, and a refresh counts as issued on the clock edge where the arbiter grants it. The block owns the clock-enable pin of the memory. The device needs `NUM_REF` refresh commands in every refresh window of `TREF_CYC` cycles. The block can spread them evenly over the window, one every `TREF_CYC/NUM_REF` cycles. It can also put out all of them back to back at the end of each window. In both modes, consecutive refresh grants are at least `TRC_CYC` cycles apart. Refreshes the arbiter cannot take at once are counted, up to a small limit, and are not lost.

The refresh request is a valid/ready channel. `ref_req` is the valid signal and `ref_gnt` is the ready signal. A handshake is a clock edge where both are high. Once the block raises `ref_req`, it holds it, together with `ref_self`, until the edge that accepts it. The arbiter may hold off a request for as long as it likes. The block does not withdraw a request while it waits.

A system request for low power (`lp_req`) stops normal traffic by dropping `ready`. The block then waits until every counted refresh has been issued, the last refresh interval has passed and the arbiter reports all banks idle. It then requests one refresh command marked as self-refresh entry (`ref_self` = 1) and pulls the clock-enable low. The clock-enable stays low for at least `TRAS_CYC` cycles. A wake request may come at any time during self-refresh and is remembered. The clock-enable rises only after the minimum stay has passed and while the system reports a stable clock. The block then holds `ready` low for `XNOP_CYC` cycles of no-operation before normal traffic resumes.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted and directly after it, `ref_req` = 0, `ref_self` = 0, `cke` = 1 and `ready` = 1.
- R2: With `burst_mode` = 0 and `ref_gnt` held high, a refresh handshake takes place every `TREF_CYC/NUM_REF` cycles. The first comes one cycle after the first full interval that follows reset.
- R3: With `burst_mode` = 0, refresh intervals that end without a grant are counted. The count saturates at `PEND_MAX`, and each counted refresh is later issued as its own handshake.
- R4: Two refresh handshakes of normal operation are at least `TRC_CYC` cycles apart. `ref_req` stays low in between.
- R5: With `burst_mode` = 1 (fixed while reset is released), the end of each `TREF_CYC`-cycle window starts `NUM_REF` handshakes spaced `TRC_CYC` apart.
- R6: Once `ref_req` is high it stays high, with `ref_self` unchanged, until a cycle where `ref_gnt` is high.
- R7: On `lp_req`, `ready` falls on the next edge. A request with `ref_self` = 1 appears only after the counted refreshes are drained, the `TRC_CYC` spacing has passed and `banks_idle` is high.
- R8: `cke` falls on the edge that accepts the `ref_self` = 1 request. While `cke` is low, `ref_req` stays low, even across refresh intervals.
- R9: `cke` stays low for at least `TRAS_CYC` cycles. A `wake_req` pulse during self-refresh is remembered. With the clock stable, `cke` rises after exactly `TRAS_CYC` low cycles.
- R10: `cke` rises only on an edge where `clk_stable` was high in the cycle before.
- R11: After `cke` rises, `ready` stays low for exactly `XNOP_CYC` cycles and then goes high.
- R12: `wake_req` has no effect outside self-refresh. `ready` and `cke` stay high and no request is raised.
- R13: When an interval ends in the same cycle as a refresh handshake, the count of outstanding refreshes stays the same. Neither event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode | input | 1 | 0: spread refreshes over the window, 1: issue all at window end |
| ref_req | output | 1 | Refresh request (valid) toward the command arbiter |
| ref_self | output | 1 | Qualifies `ref_req`: 1 means the self-refresh entry command |
| ref_gnt | input | 1 | Arbiter accepts the request on this edge (ready) |
| banks_idle | input | 1 | Arbiter reports every bank precharged |
| lp_req | input | 1 | System asks for self-refresh |
| wake_req | input | 1 | System asks to leave self-refresh |
| clk_stable | input | 1 | System reports the memory clock stable |
| cke | output | 1 | Clock-enable pin of the memory |
| ready | output | 1 | Controller may issue normal traffic |

## Verification
Two events can meet in one cycle: the end of a refresh interval and a grant of an earlier counted refresh. The bench withholds grants until two refreshes are owed. It then opens the grant so that the second grant, after the `TRC_CYC` spacing, lands exactly in the cycle where the next interval ends. Grants are counted by edge. Exactly three must occur before the following interval ends. Two grants would mean the interval was lost, and four would mean the grant was lost. The saturation limit is judged the same way, by counting the grants that follow a long stretch without any grant.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Low-power sequencer states
  typedef enum logic [2:0] {
    LP_RUN   = 3'd0,  // normal traffic, periodic refresh
    LP_DRAIN = 3'd1,  // traffic stopped, owed refreshes still going out
    LP_ENTER = 3'd2,  // self-refresh entry command requested
    LP_SELF  = 3'd3,  // clock-enable low, device refreshes itself
    LP_WAKE  = 3'd4   // clock-enable high again, no-op cycles running
  } lp_state_e;

endpackage

// File: rtl/rfsh_tick.sv
// Interval timer: one tick per refresh slot (distributed) or per window (burst).
module rfsh_tick #(
  parameter int TREF_CYC = 6400000,
  parameter int NUM_REF  = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic burst_mode,
  output logic tick
);
  localparam int INT_CYC = TREF_CYC / NUM_REF;
  localparam int CW      = $clog2(TREF_CYC + 1);
  localparam logic [CW-1:0] LIM_WIN  = CW'(TREF_CYC);
  localparam logic [CW-1:0] LIM_SLOT = CW'(INT_CYC);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = burst_mode ? LIM_WIN : LIM_SLOT;
  assign tick = en && (cnt >= lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + CW'(1);
  end

  // R2: ticks never come in adjacent cycles when an interval is longer than one
  a_r2_tick_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && INT_CYC > 1) |=> !tick);

endmodule

// File: rtl/rfsh_pend.sv
// Owed-refresh counter plus tRC spacing; drives the normal refresh request.
module rfsh_pend #(
  parameter int NUM_REF  = 8192,
  parameter int PEND_MAX = 8,
  parameter int TRC_CYC  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tick,
  input  logic burst_mode,
  input  logic take,
  output logic req,
  output logic quiet
);
  localparam int PTOP = (NUM_REF > PEND_MAX) ? NUM_REF : PEND_MAX;
  localparam int PW   = $clog2(PTOP + 1);
  localparam int GW   = $clog2(TRC_CYC + 1);
  localparam logic [PW-1:0] P_SAT  = PW'(PEND_MAX);
  localparam logic [PW-1:0] P_BURST = PW'(NUM_REF);
  localparam logic [GW-1:0] G_LOAD = GW'(TRC_CYC - 1);

  logic [PW-1:0] pend, pend_nx;
  logic [GW-1:0] gap;

  always_comb begin
    pend_nx = pend;
    if (clr) begin
      pend_nx = '0;
    end else if (tick && burst_mode) begin
      pend_nx = P_BURST;
    end else begin
      unique case ({tick, take})
        2'b10:   pend_nx = (pend >= P_SAT) ? P_SAT : pend + PW'(1);
        2'b01:   pend_nx = pend - PW'(1);
        default: pend_nx = pend;  // idle, or slot end meets grant
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      gap  <= '0;
    end else begin
      pend <= pend_nx;
      if (clr)             gap <= '0;
      else if (take)       gap <= G_LOAD;
      else if (gap != '0)  gap <= gap - GW'(1);
    end
  end

  assign req   = en && (pend != '0) && (gap == '0);
  assign quiet = (pend == '0) && (gap == '0);

  // R4: no request in the cycle after a grant when spacing exceeds one
  a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (take && TRC_CYC > 1) |=> !req);
  // R3: in distributed mode the owed count never passes its cap
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_mode && pend <= P_SAT) |=> (burst_mode || pend <= P_SAT));
  // R13: slot end together with a grant leaves the owed count unchanged
  a_r13_coincide: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && take && !burst_mode && !clr) |=> $stable(pend));
  // R6: a grant is only taken against a raised request
  a_r6_take_req: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req);

endmodule

// File: rtl/rfsh_lp_fsm.sv
// Self-refresh entry/exit sequencer: owns the clock-enable and ready.
module rfsh_lp_fsm
  import rfsh_pkg::*;
#(
  parameter int TRAS_CYC = 5,
  parameter int XNOP_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_req,
  input  logic wake_req,
  input  logic clk_stable,
  input  logic banks_idle,
  input  logic quiet,
  input  logic sr_take,
  output logic sr_req,
  output logic run_en,
  output logic cke,
  output logic ready
);
  localparam int DTOP = (TRAS_CYC > XNOP_CYC) ? TRAS_CYC : XNOP_CYC;
  localparam int DW   = $clog2(DTOP + 1);
  localparam logic [DW-1:0] D_MIN = DW'(TRAS_CYC - 1);
  localparam logic [DW-1:0] D_NOP = DW'(XNOP_CYC - 1);
  localparam logic [DW-1:0] D_TOP = DW'(DTOP);

  lp_state_e state, nxt;
  logic [DW-1:0] dwell;
  logic wake_seen;
  logic min_done, nop_done, leave_ok;

  assign min_done = dwell >= D_MIN;
  assign nop_done = dwell >= D_NOP;
  assign leave_ok = min_done && (wake_req || wake_seen) && clk_stable;

  always_comb begin
    nxt = state;
    unique case (state)
      LP_RUN:   if (lp_req)               nxt = LP_DRAIN;
      LP_DRAIN: if (quiet && banks_idle)  nxt = LP_ENTER;
      LP_ENTER: if (sr_take)              nxt = LP_SELF;
      LP_SELF:  if (leave_ok)             nxt = LP_WAKE;
      LP_WAKE:  if (nop_done)             nxt = LP_RUN;
      default:                            nxt = LP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LP_RUN;
      dwell     <= '0;
      wake_seen <= 1'b0;
      cke       <= 1'b1;
    end else begin
      state <= nxt;
      if (nxt != state)       dwell <= '0;
      else if (dwell != D_TOP) dwell <= dwell + DW'(1);
      wake_seen <= (state == LP_SELF) && (nxt == LP_SELF) && (wake_seen || wake_req);
      cke       <= (nxt != LP_SELF);
    end
  end

  assign sr_req = (state == LP_ENTER);
  assign run_en = (state == LP_RUN) || (state == LP_DRAIN);
  assign ready  = (state == LP_RUN);

  // R9: clock-enable rises only after the minimum stay in self-refresh
  a_r9_min_stay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(state) == LP_SELF && $past(dwell) >= D_MIN));
  // R10: clock-enable rises only with a stable clock reported
  a_r10_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));
  // R11: ready comes back only after the no-op cycles
  a_r11_nop_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(state) == LP_WAKE && $past(dwell) >= D_NOP));
  // R7: entry request raised only from a quiet, idle drain
  a_r7_enter_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_req) |-> $past(quiet && banks_idle));
  // R8: clock-enable low means no request of either kind
  a_r8_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!sr_req && !run_en));

endmodule

// File: rtl/rfsh_sched.sv
// SDRAM refresh scheduler top: timer, owed-refresh counter, low-power sequencer.
module rfsh_sched #(
  parameter int TREF_CYC = 6400000,
  parameter int NUM_REF  = 8192,
  parameter int TRC_CYC  = 7,
  parameter int TRAS_CYC = 5,
  parameter int XNOP_CYC = 2,
  parameter int PEND_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  output logic ref_req,
  output logic ref_self,
  input  logic ref_gnt,
  input  logic banks_idle,
  input  logic lp_req,
  input  logic wake_req,
  input  logic clk_stable,
  output logic cke,
  output logic ready
);
  logic tick, norm_req, quiet, sr_req, run_en;
  logic take, sr_take;

  assign take    = norm_req && ref_gnt;
  assign sr_take = sr_req && ref_gnt;

  rfsh_tick #(.TREF_CYC(TREF_CYC), .NUM_REF(NUM_REF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(run_en), .burst_mode(burst_mode), .tick(tick)
  );

  rfsh_pend #(.NUM_REF(NUM_REF), .PEND_MAX(PEND_MAX), .TRC_CYC(TRC_CYC)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr(!run_en), .en(run_en), .tick(tick),
    .burst_mode(burst_mode), .take(take), .req(norm_req), .quiet(quiet)
  );

  rfsh_lp_fsm #(.TRAS_CYC(TRAS_CYC), .XNOP_CYC(XNOP_CYC)) u_lp (
    .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .wake_req(wake_req),
    .clk_stable(clk_stable), .banks_idle(banks_idle), .quiet(quiet),
    .sr_take(sr_take), .sr_req(sr_req), .run_en(run_en), .cke(cke), .ready(ready)
  );

  assign ref_req  = norm_req || sr_req;
  assign ref_self = sr_req;

  // R6: an unanswered request stays up with the same qualifier
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> (ref_req && $stable(ref_self)));
  // R8: clock-enable falls only on an accepted entry request
  a_r8_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(ref_req && ref_self && ref_gnt));
  // R11: normal traffic never allowed with clock-enable low
  a_r11_ready_cke: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> cke);

endmodule

// File: tb/sim_rfsh_sched.sv
module sim_rfsh_sched;
  localparam int TREF = 40, NREF = 4, TRC = 3, TRAS = 6, XNOP = 2, PMAX = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic burst_mode = 1'b0, ref_gnt = 1'b0, banks_idle = 1'b0;
  logic lp_req = 1'b0, wake_req = 1'b0, clk_stable = 1'b1;
  logic ref_req, ref_self, cke, ready;

  rfsh_sched #(.TREF_CYC(TREF), .NUM_REF(NREF), .TRC_CYC(TRC), .TRAS_CYC(TRAS),
               .XNOP_CYC(XNOP), .PEND_MAX(PMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .ref_req(ref_req),
    .ref_self(ref_self), .ref_gnt(ref_gnt), .banks_idle(banks_idle), .lp_req(lp_req),
    .wake_req(wake_req), .clk_stable(clk_stable), .cke(cke), .ready(ready)
  );

  always #5 clk = ~clk;

  int ecnt = 0, base = 0, g_cnt = 0, g_last = 0, g_prev = 0;
  int nchk = 0, nerr = 0;
  logic s_hs = 1'b0;

  // handshake sampled mid-cycle, logged at the edge that completes it
  always @(negedge clk) begin #1; s_hs = ref_req && ref_gnt; end
  always @(posedge clk) begin
    ecnt = ecnt + 1;
    if (s_hs) begin g_prev = g_last; g_last = ecnt; g_cnt = g_cnt + 1; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic at(input int k);
    while (ecnt < base + k) @(negedge clk);
  endtask

  task automatic do_reset(input logic bm, input logic gnt, input logic idle, input logic stab);
    @(negedge clk);
    rst_n = 1'b0; burst_mode = bm; ref_gnt = gnt; banks_idle = idle;
    lp_req = 1'b0; wake_req = 1'b0; clk_stable = stab;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; base = ecnt;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R1 ref_req", ref_req, 0); chk("R1 ref_self", ref_self, 0);
    chk("R1 cke", cke, 1);         chk("R1 ready", ready, 1);
  endtask

  task automatic t_distributed();
    int g0;
    do_reset(1'b0, 1'b1, 1'b0, 1'b1); g0 = g_cnt;
    at(45);
    chk("R2 grant count", g_cnt - g0, 4);
    chk("R2 last grant edge", g_last - base, 41);
    chk("R2 interval", g_last - g_prev, 10);
  endtask

  task automatic t_saturate();
    int g0;
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    at(35); chk("R6 request held without grant", ref_req, 1);
    at(60); ref_gnt = 1'b1; g0 = g_cnt;
    at(62); chk("R4 request low in spacing", ref_req, 0);
    at(69);
    chk("R3 saturated owed count", g_cnt - g0, PMAX);
    chk("R4 grant spacing", g_last - g_prev, TRC);
  endtask

  task automatic t_coincide();
    int g0;
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    at(26); ref_gnt = 1'b1; g0 = g_cnt;
    at(39); chk("R13 grants when slot end meets grant", g_cnt - g0, 3);
    at(41); chk("R13 next slot grant", g_cnt - g0, 4);
  endtask

  task automatic t_burst();
    int g0;
    do_reset(1'b1, 1'b1, 1'b0, 1'b1); g0 = g_cnt;
    at(40); chk("R5 nothing before window end", g_cnt - g0, 0);
    at(52);
    chk("R5 burst grant count", g_cnt - g0, NREF);
    chk("R5 last burst edge", g_last - base, 50);
    chk("R5 burst spacing", g_last - g_prev, TRC);
    at(53); chk("R5 burst finished", ref_req, 0);
  endtask

  task automatic t_drain();
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    at(12); lp_req = 1'b1;
    at(13); chk("R7 ready drops", ready, 0); chk("R7 owed refresh still asked", ref_req, 1);
    chk("R7 not entry yet", ref_self, 0);
    at(16); ref_gnt = 1'b1;
    at(17); ref_gnt = 1'b0;
    at(21); chk("R7 banks busy keeps normal", ref_self, 0); chk("R7 new owed refresh", ref_req, 1);
    banks_idle = 1'b1; ref_gnt = 1'b1;
    at(22); ref_gnt = 1'b0;
    at(25); chk("R7 entry request", ref_req, 1); chk("R7 entry qualifier", ref_self, 1);
    at(27); chk("R6 entry held", ref_self, 1); chk("R6 cke before grant", cke, 1);
    ref_gnt = 1'b1;
    at(28); chk("R8 cke falls on grant", cke, 0); chk("R8 no request in self", ref_req, 0);
    ref_gnt = 1'b0; lp_req = 1'b0;
    at(32); chk("R8 slot end ignored in self", ref_req, 0);
  endtask

  task automatic fast_enter(input logic stab);
    do_reset(1'b0, 1'b1, 1'b1, stab);
    at(0); lp_req = 1'b1;
    at(3); lp_req = 1'b0;
  endtask

  task automatic t_wake_early();
    fast_enter(1'b1);
    chk("R8 cke low after fast entry", cke, 0);
    wake_req = 1'b1;
    at(4); wake_req = 1'b0;
    at(8); chk("R9 cke held for minimum", cke, 0);
    at(9); chk("R9 cke rises at minimum", cke, 1); chk("R11 ready low at exit", ready, 0);
    at(10); chk("R11 ready low in no-op", ready, 0);
    at(11); chk("R11 ready after no-ops", ready, 1);
  endtask

  task automatic t_unstable();
    fast_enter(1'b0);
    wake_req = 1'b1;
    at(14); chk("R10 cke waits for stable clock", cke, 0);
    clk_stable = 1'b1;
    at(15); chk("R10 cke rises with stable clock", cke, 1);
    wake_req = 1'b0;
  endtask

  task automatic t_wake_ignored();
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    at(4); wake_req = 1'b1;
    at(8);
    chk("R12 ready unchanged", ready, 1); chk("R12 cke unchanged", cke, 1);
    chk("R12 no request", ref_req, 0);
    wake_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_distributed();
    t_saturate();
    t_coincide();
    t_burst();
    t_drain();
    t_wake_early();
    t_unstable();
    t_wake_ignored();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule